// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiplier

This block multiplies two 64-bit integers and returns the full 128-bit product as a high word and a low word. It recodes the multiplier two bits at a time into Booth digits in {-2,-1,0,+1,+2}. Each digit passes through four registered steps in a fixed order: digit decode, choice of multiple (0, X or 2X), signed partial product aligned to its weight, and accumulation. A new digit enters the decode step every clock, so the four steps of successive digits overlap.

The multiplier runs on a clock at twice the rate of the integer pipeline that feeds it. A caller raises `start` for one clock with the operands and the mode bits, watches `busy`, and takes the product when `done` pulses. In signed mode the operands are sign-extended by two bits. In unsigned mode they are zero-extended, so the top Booth digit comes out right. A short mode uses only the low 32 bits of each operand and needs 17 digits instead of 33.

Top module: `booth_mul_r4`

## Requirements
- R1: After reset, `busy` and `done` are low and `prod_hi`/`prod_lo` are zero.
- R2: A `start` sampled while `busy` is low is accepted, and `busy` is high on the following clock.
- R3: In full mode (`short_mode`=0), `done` pulses exactly 36 multiplier clocks after the clock edge that accepts `start` (18 pipeline cycles).
- R4: In short mode (`short_mode`=1), `done` pulses exactly 20 multiplier clocks after the accepting edge (10 pipeline cycles).
- R5: With `is_signed`=1 and full mode, {`prod_hi`,`prod_lo`} is the two's-complement 128-bit product of the signed 64-bit operands.
- R6: With `is_signed`=0 and full mode, {`prod_hi`,`prod_lo`} is the unsigned 128-bit product of the operands.
- R7: In short mode, bits 63:32 of both operands are ignored. The result is the product of bits 31:0, taken as signed or unsigned per `is_signed`, extended in the same way to 128 bits.
- R8: A `start` sampled while `busy` is high is ignored. The running operation keeps its operands, its mode and its latency.
- R9: `done` lasts one clock. `busy` is low whenever `done` is high, and `busy` falls only together with `done`.
- R10: While `busy` is low and no `start` is accepted, `prod_hi`/`prod_lo` hold their value.
- R11: Multiplier bit patterns that call for each Booth digit value (+1, +2, -1, -2 and 0, including long runs of ones) give exact products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Multiplier clock, twice the pipeline rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request to begin a multiply |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| short_mode | input | 1 | 1: multiply the low 32 bits only |
| op_a | input | 64 | Multiplicand |
| op_b | input | 64 | Multiplier (Booth-recoded) |
| busy | output | 1 | High from the accepted start until done |
| done | output | 1 | One-clock pulse when the product is valid |
| prod_hi | output | 64 | Product bits 127:64 |
| prod_lo | output | 64 | Product bits 63:0 |

## Verification
Random operand pairs in both sign modes exercise general carry and sign behaviour. Zero operands, all-ones operands and the most-negative value separate the signed and unsigned handling of the top Booth digit, since all-ones means -1 in one mode and 2^64-1 in the other. Alternating-bit and long-run multipliers force every digit value, and -2 in particular, so an error in the choice of multiple or in the negation shows up. Short-mode runs put junk in the upper operand halves so that any leak of those bits changes the result. A second start during a run, with different operands, shows whether the design wrongly accepts it.

// File: rtl/booth_mul_r4.sv
module booth_mul_r4 #(
  parameter int WIDTH   = 64,
  parameter int SHORT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic             short_mode,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);
  localparam int XW     = WIDTH + 2;
  localparam int MW     = XW + 1;
  localparam int AW     = 2 * XW;
  localparam int NDIG   = XW / 2;
  localparam int NDIG_S = (SHORT_W + 2) / 2;
  localparam int IW     = $clog2(NDIG + 1);

  function automatic logic [XW-1:0] widen(input logic [WIDTH-1:0] v, input logic sgn, input logic shrt);
    logic [XW-1:0] r;
    if (shrt) r = {{(XW-SHORT_W){sgn & v[SHORT_W-1]}}, v[SHORT_W-1:0]};
    else      r = {{2{sgn & v[WIDTH-1]}}, v};
    return r;
  endfunction

  logic [XW-1:0] xe;
  logic [XW:0]   ysh;
  logic [IW-1:0] icnt;
  logic          issuing, short_q;
  logic          accept, last_issue;

  assign accept     = start & ~busy;
  assign last_issue = (icnt == (short_q ? IW'(NDIG_S-1) : IW'(NDIG-1)));

  logic neg_d, one_d, two_d;
  assign one_d = ysh[1] ^ ysh[0];
  assign two_d = (ysh[2:0] == 3'b011) | (ysh[2:0] == 3'b100);
  assign neg_d = ysh[2] & ~(ysh[1] & ysh[0]);

  logic          v1, last1, neg1, one1, two1;
  logic [IW-1:0] idx1;
  logic          v2, last2, neg2;
  logic [MW-1:0] mag2;
  logic [IW-1:0] idx2;
  logic          v3, last3;
  logic [AW-1:0] pp3;
  logic [AW-1:0] acc;

  logic signed [MW-1:0] smag;
  logic [AW-1:0]        pp_wide;
  assign smag    = neg2 ? -$signed(mag2) : $signed(mag2);
  assign pp_wide = {{(AW-MW){smag[MW-1]}}, smag} << {idx2, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xe <= '0; ysh <= '0; icnt <= '0; issuing <= 1'b0; short_q <= 1'b0;
      busy <= 1'b0; done <= 1'b0; acc <= '0;
      v1 <= 1'b0; last1 <= 1'b0; neg1 <= 1'b0; one1 <= 1'b0; two1 <= 1'b0; idx1 <= '0;
      v2 <= 1'b0; last2 <= 1'b0; neg2 <= 1'b0; mag2 <= '0; idx2 <= '0;
      v3 <= 1'b0; last3 <= 1'b0; pp3 <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        xe      <= widen(op_a, is_signed, short_mode);
        ysh     <= {widen(op_b, is_signed, short_mode), 1'b0};
        icnt    <= '0;
        issuing <= 1'b1;
        short_q <= short_mode;
        acc     <= '0;
        busy    <= 1'b1;
      end else if (issuing) begin
        ysh     <= {2'b00, ysh[XW:2]};
        icnt    <= icnt + 1'b1;
        issuing <= ~last_issue;
      end
      // step 1: Booth digit decode
      v1    <= issuing;
      last1 <= issuing & last_issue;
      neg1  <= neg_d;
      one1  <= one_d;
      two1  <= two_d;
      idx1  <= icnt;
      // step 2: choice of multiple
      v2    <= v1;
      last2 <= last1;
      neg2  <= neg1;
      idx2  <= idx1;
      mag2  <= one1 ? {xe[XW-1], xe} : (two1 ? {xe, 1'b0} : '0);
      // step 3: aligned signed partial product
      v3    <= v2;
      last3 <= last2;
      pp3   <= pp_wide;
      // step 4: accumulate
      if (v3) acc <= acc + pp3;
      if (v3 && last3) begin
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  assign prod_hi = acc[2*WIDTH-1:WIDTH];
  assign prod_lo = acc[WIDTH-1:0];

  logic [7:0] lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat <= '0;
    else if (accept)   lat <= '0;
    else if (busy)     lat <= lat + 1'b1;
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) accept |=> busy); // R2
  AST_FULL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (done && !short_q) |-> lat == 8'(NDIG + 3)); // R3
  AST_SHORT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (done && short_q) |-> lat == 8'(NDIG_S + 3)); // R4
  AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rst_n) (start && busy) |=> $stable(short_q) && $stable(xe)); // R8
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R9
  AST_PROD_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable({prod_hi, prod_lo})); // R10
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) v2 |-> $countones(mag2 ^ {xe[XW-1], xe}) == 0 || $countones(mag2 ^ {xe, 1'b0}) == 0 || mag2 == '0); // R11
endmodule

// File: tb/tb_booth_mul_r4.sv
module tb_booth_mul_r4;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic        short_mode = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        busy, done;
  logic [63:0] prod_hi, prod_lo;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mul_r4 dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .short_mode(short_mode), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  function automatic logic [127:0] model(input logic [63:0] a, input logic [63:0] b,
                                         input logic sgn, input logic shrt);
    logic [127:0] ea, eb;
    if (shrt) begin
      ea = sgn ? {{96{a[31]}}, a[31:0]} : {96'b0, a[31:0]};
      eb = sgn ? {{96{b[31]}}, b[31:0]} : {96'b0, b[31:0]};
    end else begin
      ea = sgn ? {{64{a[63]}}, a} : {64'b0, a};
      eb = sgn ? {{64{b[63]}}, b} : {64'b0, b};
    end
    return ea * eb;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [63:0] a, input logic [63:0] b, input logic sgn, input logic shrt);
    @(negedge clk);
    op_a = a; op_b = b; is_signed = sgn; short_mode = shrt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  task automatic mul_check(input logic [63:0] a, input logic [63:0] b, input logic sgn,
                           input logic shrt, input string req);
    int lat;
    logic [127:0] exp;
    exp = model(a, b, sgn, shrt);
    launch(a, b, sgn, shrt);
    wait_done(lat);
    check(lat == (shrt ? 20 : 36), shrt ? "R4 latency" : "R3 latency", 128'(lat), shrt ? 128'd20 : 128'd36);
    check({prod_hi, prod_lo} == exp, req, {prod_hi, prod_lo}, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1 control", {126'b0, busy, done}, 128'd0);
    check({prod_hi, prod_lo} == '0, "R1 product", {prod_hi, prod_lo}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_accept();
    int lat;
    launch(64'd7, 64'd9, 1'b1, 1'b0);
    check(busy, "R2 busy after start", 128'(busy), 128'd1);
    wait_done(lat);
    check(!busy, "R9 busy low with done", 128'(busy), 128'd0);
    @(negedge clk);
    check(!done, "R9 done one clock", 128'(done), 128'd0);
  endtask

  task automatic t_signed();
    mul_check(64'd0, 64'h1234_5678_9abc_def0, 1'b1, 1'b0, "R5 zero");
    mul_check('1, '1, 1'b1, 1'b0, "R5 all ones");
    mul_check(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 1'b0, "R5 most negative squared");
    mul_check(64'h8000_0000_0000_0000, '1, 1'b1, 1'b0, "R5 most negative by -1");
    mul_check(64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000, 1'b1, 1'b0, "R5 max by min");
    for (int i = 0; i < 6; i++)
      mul_check({$urandom, $urandom}, {$urandom, $urandom}, 1'b1, 1'b0, "R5 random");
  endtask

  task automatic t_unsigned();
    mul_check('1, '1, 1'b0, 1'b0, "R6 all ones");
    mul_check(64'h8000_0000_0000_0000, 64'd2, 1'b0, 1'b0, "R6 top bit");
    mul_check(64'd0, '1, 1'b0, 1'b0, "R6 zero");
    for (int i = 0; i < 6; i++)
      mul_check({$urandom, $urandom}, {$urandom, $urandom}, 1'b0, 1'b0, "R6 random");
  endtask

  task automatic t_digits();
    mul_check(64'h1357_9bdf_2468_ace0, 64'haaaa_aaaa_aaaa_aaaa, 1'b1, 1'b0, "R11 alternating -2/-1");
    mul_check(64'hfedc_ba98_7654_3210, 64'h6666_6666_6666_6666, 1'b0, 1'b0, "R11 +2/-2 mix");
    mul_check(64'h0123_4567_89ab_cdef, 64'h00ff_ff00_0fff_fff0, 1'b1, 1'b0, "R11 runs of ones");
    mul_check(64'h8000_0000_0000_0001, 64'h5555_5555_5555_5555, 1'b0, 1'b0, "R11 all +1");
  endtask

  task automatic t_short();
    mul_check(64'hdead_beef_ffff_ffff, 64'h1234_5678_8000_0000, 1'b1, 1'b1, "R7 signed -1 by min");
    mul_check(64'hdead_beef_ffff_ffff, 64'h1234_5678_ffff_ffff, 1'b0, 1'b1, "R7 unsigned all ones");
    mul_check(64'h5a5a_5a5a_0000_0000, 64'hffff_ffff_1234_5678, 1'b1, 1'b1, "R7 zero low half");
    for (int i = 0; i < 4; i++)
      mul_check({$urandom, $urandom}, {$urandom, $urandom}, 1'(i % 2), 1'b1, "R7 random");
  endtask

  task automatic t_busy_start();
    int lat;
    logic [127:0] exp;
    exp = model(64'h0fed_cba9_8765_4321, 64'hffff_ffff_0000_0003, 1'b1, 1'b0);
    launch(64'h0fed_cba9_8765_4321, 64'hffff_ffff_0000_0003, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    op_a = 64'd5; op_b = 64'd6; is_signed = 1'b0; short_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
    check(lat == 36, "R8 latency kept", 128'(lat), 128'd36);
    check({prod_hi, prod_lo} == exp, "R8 result kept", {prod_hi, prod_lo}, exp);
  endtask

  task automatic t_hold();
    logic [127:0] exp;
    exp = model(64'h1111_2222_3333_4444, 64'h9999_8888_7777_6666, 1'b0, 1'b0);
    mul_check(64'h1111_2222_3333_4444, 64'h9999_8888_7777_6666, 1'b0, 1'b0, "R6 hold setup");
    op_a = '1; op_b = '1; is_signed = 1'b1;
    repeat (10) @(negedge clk);
    check({prod_hi, prod_lo} == exp, "R10 product held", {prod_hi, prod_lo}, exp);
    check(!busy, "R10 idle", 128'(busy), 128'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_accept();
    t_signed();
    t_unsigned();
    t_digits();
    t_short();
    t_busy_start();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule